// File: doc/BRIEF.md
# Function Input Priority Multiplexer

This block carries pad input levels from a bank of pins to the input wires of on-chip peripheral functions. Every pin has a small select field that chooses one of its slots. Each slot either names a function input or is empty. The output side of the chip decodes the same field with the same slot numbers, so one setting connects a bidirectional function in both directions.

The mux is built per function, not per pin. For each function input, a comparator on every pin checks whether that pin's select field points at the slot where the function sits. A fixed-order priority stage then passes exactly one pin's level to the function. If two pins are set up for the same function, their levels are never combined. If no pin asks for the function, the wire rests at an idle level set for that function. A function that only one pin can reach gets a plain gate instead of a priority stage. The whole path is combinational: there is no clock and no state, so there are no states or transitions to list.

The pin-to-slot wiring is a parameter. Its default describes four pins with four slots each. Slot 0 of every pin carries that pin's general-purpose input. Slot 1 of every pin feeds one shared receive line. Two further shared functions sit on slots 2 and 3. Some slots are output-only and feed no input wire.

Top module: `fimux_fn_input_top`

## Requirements
- R1: Each pin has a 2-bit select value s (0 to 3) that chooses slot s of that pin. With the default wiring, pin p slot 0 feeds function p (general-purpose input of pin p). Slot 1 of every pin feeds function 4. Slot 2 feeds function 5 on pins 0 and 2, and function 6 on pins 1 and 3. Slot 3 of pin 2 feeds function 6. Slot 3 of pins 0, 1 and 3 is empty.
- R2: A pin is a candidate for a function only while its select value equals the slot where that function sits on that pin. When exactly one candidate exists, the function input equals that pin's level.
- R3: When several pins are candidates for one function, the function input equals the level of the lowest-numbered candidate pin. The levels of the other candidates have no effect.
- R4: When no pin is a candidate for a function, the function input is at its idle level. With the default settings, function 4 idles at 1 and all other functions idle at 0.
- R5: A function that only one pin can reach (functions 0 to 3) equals its pin's level when that pin's select is 0. Otherwise it equals its idle level of 0.
- R6: Selecting an empty slot makes that pin a candidate for no function. Its level then reaches no function input.
- R7: Priority goes by pin number and is independent of the select values. Function 6 chosen by pin 2 (select 3) and by pin 3 (select 2) follows pin 2.
- R8: Function inputs follow select and level changes combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pad_sel_i | input | NUM_PINS*SEL_W | Select field per pin; pin p occupies bits [p*SEL_W +: SEL_W] |
| pad_level_i | input | NUM_PINS | Level seen at each pad's input buffer; bit p is pin p |
| fn_in_o | output | NUM_FUNCS | One input wire per function; bit f is function f |

## Verification
The bench sweeps every combination of the four select fields together with every pattern of the four pad levels. This covers all candidate sets for each shared function: none, one, and several. Walking all level patterns for each candidate set is what shows the lowest-numbered pin wins and the others are ignored. Directed cases add three checks: an empty slot keeping a pad out of every function, priority going against select order on function 6, and an output changing with no clock edge.

// File: rtl/fimux_pkg.sv
package fimux_pkg;

    localparam int ROUTE_W = 8;
    localparam logic [ROUTE_W-1:0] FN_NONE = 8'hFF;

    localparam int DEF_PINS = 4;
    localparam int DEF_WAYS = 4;

    // Default slot wiring: one ROUTE_W entry per (pin, slot), entry index pin*WAYS+slot.
    function automatic logic [DEF_PINS*DEF_WAYS*ROUTE_W-1:0] default_route();
        logic [DEF_PINS*DEF_WAYS*ROUTE_W-1:0] r;
        logic [ROUTE_W-1:0] e;
        r = '0;
        for (int p = 0; p < DEF_PINS; p++) begin
            for (int s = 0; s < DEF_WAYS; s++) begin
                case (s)
                    0:       e = ROUTE_W'(p);
                    1:       e = 8'd4;
                    2:       e = (p % 2 == 0) ? 8'd5 : 8'd6;
                    default: e = (p == 2) ? 8'd6 : FN_NONE;
                endcase
                r[(p*DEF_WAYS+s)*ROUTE_W +: ROUTE_W] = e;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fimux_pin_decode.sv
// Per-pin comparators: which function inputs this pin currently requests.
module fimux_pin_decode #(
    parameter int NUM_FUNCS = 7,
    parameter int MUX_WAYS  = 4,
    parameter int SEL_W     = 2,
    parameter logic [MUX_WAYS*fimux_pkg::ROUTE_W-1:0] PIN_ROUTE = '1
) (
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_FUNCS-1:0] req_o
);
    localparam int RW = fimux_pkg::ROUTE_W;

    always_comb begin
        req_o = '0;
        for (int s = 0; s < MUX_WAYS; s++) begin
            for (int f = 0; f < NUM_FUNCS; f++) begin
                if (PIN_ROUTE[s*RW +: RW] == RW'(f) && sel_i == SEL_W'(s)) begin
                    req_o[f] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fimux_prio_pick.sv
// Lowest-numbered requesting pin wins; idle level when nobody requests.
module fimux_prio_pick #(
    parameter int   NUM_PINS = 4,
    parameter logic IDLE     = 1'b0
) (
    input  logic [NUM_PINS-1:0] req_i,
    input  logic [NUM_PINS-1:0] level_i,
    output logic [NUM_PINS-1:0] grant_o,
    output logic                fn_o
);
    always_comb begin
        grant_o = '0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (req_i[p]) begin
                grant_o    = '0;
                grant_o[p] = 1'b1;
            end
        end
        fn_o = (|grant_o) ? |(grant_o & level_i) : IDLE;
    end
endmodule

// File: rtl/fimux_solo_gate.sv
// Single reachable pin: a gate on match and level, idle otherwise.
module fimux_solo_gate #(
    parameter int   NUM_PINS = 4,
    parameter int   PIN      = 0,
    parameter logic IDLE     = 1'b0
) (
    input  logic [NUM_PINS-1:0] req_i,
    input  logic [NUM_PINS-1:0] level_i,
    output logic [NUM_PINS-1:0] grant_o,
    output logic                fn_o
);
    always_comb begin
        grant_o      = '0;
        grant_o[PIN] = req_i[PIN];
        fn_o = (req_i[PIN] & level_i[PIN]) | (~req_i[PIN] & IDLE);
    end
endmodule

// File: rtl/fimux_fn_input_top.sv
module fimux_fn_input_top #(
    parameter int NUM_PINS  = 4,
    parameter int MUX_WAYS  = 4,
    parameter int NUM_FUNCS = 7,
    parameter int SEL_W     = (MUX_WAYS > 1) ? $clog2(MUX_WAYS) : 1,
    parameter logic [NUM_PINS*MUX_WAYS*fimux_pkg::ROUTE_W-1:0] ROUTE_MAP = fimux_pkg::default_route(),
    parameter logic [NUM_FUNCS-1:0] IDLE_LVL = 7'b001_0000
) (
    input  logic [NUM_PINS*SEL_W-1:0] pad_sel_i,
    input  logic [NUM_PINS-1:0]       pad_level_i,
    output logic [NUM_FUNCS-1:0]      fn_in_o
);
    localparam int RW     = fimux_pkg::ROUTE_W;
    localparam int PIN_RB = MUX_WAYS * RW;

    function automatic int reach_count(int f);
        int n = 0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int s = 0; s < MUX_WAYS; s++) begin
                if (ROUTE_MAP[(p*MUX_WAYS+s)*RW +: RW] == RW'(f)) n++;
            end
        end
        return n;
    endfunction

    function automatic int reach_pin(int f);
        int r = 0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            for (int s = 0; s < MUX_WAYS; s++) begin
                if (ROUTE_MAP[(p*MUX_WAYS+s)*RW +: RW] == RW'(f)) r = p;
            end
        end
        return r;
    endfunction

    logic [NUM_FUNCS-1:0] pin_req [NUM_PINS];
    logic [NUM_PINS-1:0]  fn_req  [NUM_FUNCS];
    logic [NUM_PINS-1:0]  fn_gnt  [NUM_FUNCS];
    logic [NUM_FUNCS*NUM_PINS-1:0] req_flat;
    logic [NUM_FUNCS*NUM_PINS-1:0] gnt_flat;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        fimux_pin_decode #(
            .NUM_FUNCS (NUM_FUNCS),
            .MUX_WAYS  (MUX_WAYS),
            .SEL_W     (SEL_W),
            .PIN_ROUTE (ROUTE_MAP[p*PIN_RB +: PIN_RB])
        ) u_dec (
            .sel_i (pad_sel_i[p*SEL_W +: SEL_W]),
            .req_o (pin_req[p])
        );
    end

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_tr
            assign fn_req[f][p] = pin_req[p][f];
        end
        assign req_flat[f*NUM_PINS +: NUM_PINS] = fn_req[f];
        assign gnt_flat[f*NUM_PINS +: NUM_PINS] = fn_gnt[f];

        if (reach_count(f) == 0) begin : g_unreached
            assign fn_gnt[f]  = '0;
            assign fn_in_o[f] = IDLE_LVL[f] | (|(fn_req[f] & '0));
        end else if (reach_count(f) == 1) begin : g_solo
            fimux_solo_gate #(
                .NUM_PINS (NUM_PINS),
                .PIN      (reach_pin(f)),
                .IDLE     (IDLE_LVL[f])
            ) u_gate (
                .req_i   (fn_req[f]),
                .level_i (pad_level_i),
                .grant_o (fn_gnt[f]),
                .fn_o    (fn_in_o[f])
            );
        end else begin : g_shared
            fimux_prio_pick #(
                .NUM_PINS (NUM_PINS),
                .IDLE     (IDLE_LVL[f])
            ) u_pick (
                .req_i   (fn_req[f]),
                .level_i (pad_level_i),
                .grant_o (fn_gnt[f]),
                .fn_o    (fn_in_o[f])
            );
        end
    end
endmodule

// File: rtl/fimux_fn_input_chk.sv
module fimux_fn_input_chk #(
    parameter int NUM_PINS  = 4,
    parameter int NUM_FUNCS = 7,
    parameter logic [NUM_FUNCS-1:0] IDLE_LVL = '0
) (
    input logic [NUM_PINS-1:0]           pad_level_i,
    input logic [NUM_FUNCS-1:0]          fn_in_o,
    input logic [NUM_FUNCS*NUM_PINS-1:0] req_flat,
    input logic [NUM_FUNCS*NUM_PINS-1:0] gnt_flat
);
    always_comb begin
        for (int f = 0; f < NUM_FUNCS; f++) begin
            // R3: never more than one pin granted to a function
            assert_single_grant_R3: assert ($onehot0(gnt_flat[f*NUM_PINS +: NUM_PINS]))
                else $error("R3 more than one pin granted to function %0d", f);
            // R4: no requester means idle level and no grant
            if (req_flat[f*NUM_PINS +: NUM_PINS] == '0) begin
                assert_idle_level_R4: assert (fn_in_o[f] == IDLE_LVL[f] &&
                                              gnt_flat[f*NUM_PINS +: NUM_PINS] == '0)
                    else $error("R4 function %0d not idle", f);
            end
            for (int p = 0; p < NUM_PINS; p++) begin
                if (gnt_flat[f*NUM_PINS + p]) begin
                    // R2: granted pin's level reaches the function
                    assert_grant_level_R2: assert (fn_in_o[f] == pad_level_i[p])
                        else $error("R2 function %0d level differs from pin %0d", f, p);
                    // R7: grant only to a requester with no lower-numbered requester
                    assert_lowest_wins_R7: assert (req_flat[f*NUM_PINS + p] &&
                        ((req_flat[f*NUM_PINS +: NUM_PINS] & ((NUM_PINS'(1) << p) - NUM_PINS'(1))) == '0))
                        else $error("R7 function %0d grant order wrong", f);
                end
            end
        end
    end
endmodule

bind fimux_fn_input_top fimux_fn_input_chk #(
    .NUM_PINS  (NUM_PINS),
    .NUM_FUNCS (NUM_FUNCS),
    .IDLE_LVL  (IDLE_LVL)
) u_chk (
    .pad_level_i (pad_level_i),
    .fn_in_o     (fn_in_o),
    .req_flat    (req_flat),
    .gnt_flat    (gnt_flat)
);

// File: tb/fimux_fn_input_top_tb_top.sv
module fimux_fn_input_top_tb_top;
    logic       clk = 1'b0;
    logic [7:0] sel;
    logic [3:0] lvl;
    logic [6:0] fn_out;
    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fimux_fn_input_top dut_i (
        .pad_sel_i   (sel),
        .pad_level_i (lvl),
        .fn_in_o     (fn_out)
    );

    // Slot table from R1: function fed by pin p slot s, -1 when empty.
    function automatic int slot_fn(int p, int s);
        case (s)
            0: return p;
            1: return 4;
            2: return (p == 0 || p == 2) ? 5 : 6;
            default: return (p == 2) ? 6 : -1;
        endcase
    endfunction

    function automatic logic [6:0] expect_out(logic [7:0] s, logic [3:0] l);
        logic [6:0] e;
        e = 7'b001_0000;                      // R4 idle levels
        for (int f = 0; f < 7; f++) begin
            for (int p = 3; p >= 0; p--) begin  // lowest pin written last wins
                if (slot_fn(p, int'(s[p*2 +: 2])) == f) e[f] = l[p];
            end
        end
        return e;
    endfunction

    function automatic int cand_count(logic [7:0] s, int f);
        int n = 0;
        for (int p = 0; p < 4; p++) if (slot_fn(p, int'(s[p*2 +: 2])) == f) n++;
        return n;
    endfunction

    task automatic check(string tag, logic [6:0] exp);
        vectors++;
        if (fn_out !== exp) begin
            errors++;
            $display("FAIL %s sel=%h lvl=%h actual=%b expected=%b", tag, sel, lvl, fn_out, exp);
        end
    endtask

    task automatic apply(logic [7:0] s, logic [3:0] l);
        @(posedge clk);
        sel = s;
        lvl = l;
        @(negedge clk);
    endtask

    initial begin
        sel = '0;
        lvl = '0;
        #1;
        check("R4 reset state", 7'b001_0000);

        // R1: all pins on slot 1, function 4 follows pin 0
        apply(8'b01_01_01_01, 4'b1110);
        check("R1 slot1 shared rx", 7'b000_0000);
        // R6: pins 0,1,3 on empty slot 3, pin 2 on slot 0; only gpio2 moves
        apply(8'b11_00_11_11, 4'b1111);
        check("R6 empty slot", 7'b001_0100);
        // R7: pin2 select 3 and pin3 select 2 both pick function 6, pin 2 wins
        apply(8'b10_11_00_00, 4'b0100);
        check("R7 pin order over select", 7'b100_0000 | 7'b000_0001 & 7'b0 | 7'b001_0000);
        apply(8'b10_11_00_00, 4'b1000);
        check("R7 lower pin low", 7'b001_0000);
        // R8: level change seen with no clock edge
        apply(8'b00_00_00_00, 4'b0000);
        lvl = 4'b0001;
        #1;
        check("R8 combinational", 7'b001_0001);

        // Exhaustive sweep over all selects and levels
        for (int s = 0; s < 256; s++) begin
            for (int l = 0; l < 16; l++) begin
                logic [6:0] e;
                apply(8'(s), 4'(l));
                e = expect_out(8'(s), 4'(l));
                vectors++;
                for (int f = 0; f < 7; f++) begin
                    if (fn_out[f] !== e[f]) begin
                        errors++;
                        if (f < 4)
                            $display("FAIL R5 fn%0d sel=%h lvl=%h actual=%b expected=%b", f, sel, lvl, fn_out[f], e[f]);
                        else if (cand_count(8'(s), f) == 0)
                            $display("FAIL R4 fn%0d sel=%h lvl=%h actual=%b expected=%b", f, sel, lvl, fn_out[f], e[f]);
                        else if (cand_count(8'(s), f) == 1)
                            $display("FAIL R2 fn%0d sel=%h lvl=%h actual=%b expected=%b", f, sel, lvl, fn_out[f], e[f]);
                        else
                            $display("FAIL R3 fn%0d sel=%h lvl=%h actual=%b expected=%b", f, sel, lvl, fn_out[f], e[f]);
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule